// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM with Zero-Turnaround Writes

This block is a synthesizable behavioural model of a small synchronous static RAM. Address, controls, chip enables and data are all captured on the rising clock edge. A read returns its word two enabled edges after the address is loaded. A write takes its data from the data-in bus two enabled edges after its address. Because both directions share the same two-cycle distance between address and data, reads and writes can be issued on every cycle in any mix, and the shared data bus never needs an idle cycle when it changes direction.

A load (advance/load control low) starts a new read, write or deselect cycle at an external address. An advance (control high) keeps the previous cycle type and steps a 2-bit burst counter. The low two address bits then follow either an interleaved order (start XOR count) or a linear order (start plus count, wrapping within four words), chosen by the burst-order input. An active-low clock enable freezes the whole block.

A small state machine holds the type of the current cycle. Its states are IDLE (deselected), READ and WRITE. LOAD_READ and LOAD_WRITE move it to READ or WRITE when the chip is selected. LOAD_DESELECT moves it to IDLE when any chip enable is inactive. On ADVANCE it stays in the state it is in. Reset enters IDLE.

Top module: `nt_burst_sram`

## Requirements
- R1: After reset `dout_oe` is 0, `dout` is 0 and the cycle state is IDLE.
- R2: While `cke_n` is 1, every other synchronous input is ignored: `dout`, `dout_oe`, the cycle state, the burst counter and both pipeline stages keep their values.
- R3: A load (`adv_ld`=0) with the chip selected and `we_n`=1 is a read. The addressed word appears on `dout`, with `dout_oe`=1, after the second enabled rising edge that follows the load edge.
- R4: A load with the chip selected and `we_n`=0 is a write. Its data is taken from `din` at the second enabled edge after the address edge. Bit `bw_n[i]`=0 writes byte i (bits 8i+7..8i). Bytes whose `bw_n` bit is 1 keep their old contents. The byte enables are sampled with the address.
- R5: An advance (`adv_ld`=1) continues the previous cycle type. `we_n` and the chip enables are ignored on an advance, and an advance after a deselect stays deselected.
- R6: The chip is selected at a load only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Otherwise the cycle is a deselect, which writes nothing and leaves `dout_oe` at 0.
- R7: With `mode`=1 (interleaved), the k-th access of a burst (k = 0 at the load, counting mod 4) uses the loaded upper address bits, and its low two bits are start XOR k.
- R8: With `mode`=0 (linear), the low two address bits of the k-th access are (start + k) mod 4, and the upper bits are unchanged.
- R9: `dout_oe` is 1 only in the cycle after a read's data edge. It is 0 for write and deselect slots.
- R10: Reads and writes may be issued on consecutive cycles in any mix, with no idle cycle. A read issued after a write to the same word returns the newer data, merged byte by byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control and pipeline state |
| cke_n | input | 1 | Active-low clock enable; high freezes the block |
| adv_ld | input | 1 | 0 = load a new address and cycle type, 1 = advance the burst |
| we_n | input | 1 | Cycle type at a load: 0 = write, 1 = read |
| bw_n | input | NB | Active-low per-byte write enables |
| ce1_n | input | 1 | Active-low chip enable |
| ce2 | input | 1 | Active-high chip enable |
| ce3_n | input | 1 | Active-low chip enable |
| mode | input | 1 | Burst order: 1 = interleaved, 0 = linear |
| addr | input | AW | Word address |
| din | input | 8*NB | Write data (input half of the shared bus) |
| dout | output | 8*NB | Read data (output half of the shared bus) |
| dout_oe | output | 1 | High when `dout` should drive the shared bus |

## Verification
Two events can meet in one cycle. In the first, an older write commits its data from `din` at the same edge where a younger read of the same word, issued one cycle later, enters its second pipeline stage. The read then executes on the next edge and must see the merged bytes. Directed write/read pairs on one address, together with a random mix of partial byte masks, bursts and loads, provoke this case. Each returned word is judged against a bench model that applies the masked write before it serves the read. The second meeting is a clock-enable stall that lands while the pipeline holds both a write and a read. It is checked by comparing the frozen outputs against the values from before the stall.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } cyc_e;
endpackage

// File: rtl/nbs_cycle_fsm.sv
module nbs_cycle_fsm
    import nbs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic adv_ld,
    input  logic we_n,
    input  logic sel,
    output cyc_e cyc_now,
    output cyc_e cyc_q
);
    cyc_e state_q;
    cyc_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else if (en)
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!adv_ld) begin
            if (!sel)
                state_d = ST_IDLE;
            else if (we_n)
                state_d = ST_READ;
            else
                state_d = ST_WRITE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_READ:  state_d = ST_READ;
                ST_WRITE: state_d = ST_WRITE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    assign cyc_now = state_d;
    assign cyc_q   = state_q;
endmodule

// File: rtl/nbs_burst_addr.sv
module nbs_burst_addr #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          adv_ld,
    input  logic          mode,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] cur_addr
);
    localparam int CW = 2;

    logic [AW-1:0] base_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic [CW-1:0] low;

    always_comb begin
        if (!adv_ld) begin
            cnt_d    = '0;
            low      = addr[CW-1:0];
            cur_addr = addr;
        end else begin
            cnt_d    = cnt_q + 1'b1;
            low      = mode ? (base_q[CW-1:0] ^ cnt_d) : (base_q[CW-1:0] + cnt_d);
            cur_addr = {base_q[AW-1:CW], low};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (en) begin
            cnt_q <= cnt_d;
            if (!adv_ld)
                base_q <= addr;
        end
    end
endmodule

// File: rtl/nbs_pipe_array.sv
module nbs_pipe_array
    import nbs_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  cyc_e            cyc,
    input  logic [AW-1:0]   a_in,
    input  logic [NB-1:0]   be_in,
    input  logic [NB*8-1:0] din,
    output logic [NB*8-1:0] dout,
    output logic            dout_oe
);
    localparam int DW    = NB * 8;
    localparam int DEPTH = 1 << AW;
    localparam int NSTG  = 2;

    typedef struct packed {
        cyc_e          op;
        logic [AW-1:0] a;
        logic [NB-1:0] be;
    } stg_t;

    stg_t          stg_q [NSTG];
    stg_t          head;
    logic [DW-1:0] mem [DEPTH];

    assign head = '{op: cyc, a: a_in, be: be_in};

    for (genvar s = 0; s < NSTG; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                stg_q[s] <= '{op: ST_IDLE, a: '0, be: '0};
            else if (en)
                stg_q[s] <= (s == 0) ? head : stg_q[(s == 0) ? 0 : s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (en && stg_q[NSTG-1].op == ST_WRITE) begin
            for (int b = 0; b < NB; b++) begin
                if (stg_q[NSTG-1].be[b])
                    mem[stg_q[NSTG-1].a][b*8 +: 8] <= din[b*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_oe <= 1'b0;
        end else if (en) begin
            dout_oe <= (stg_q[NSTG-1].op == ST_READ);
            if (stg_q[NSTG-1].op == ST_READ)
                dout <= mem[stg_q[NSTG-1].a];
        end
    end
endmodule

// File: rtl/nt_burst_sram.sv
module nt_burst_sram
    import nbs_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cke_n,
    input  logic            adv_ld,
    input  logic            we_n,
    input  logic [NB-1:0]   bw_n,
    input  logic            ce1_n,
    input  logic            ce2,
    input  logic            ce3_n,
    input  logic            mode,
    input  logic [AW-1:0]   addr,
    input  logic [NB*8-1:0] din,
    output logic [NB*8-1:0] dout,
    output logic            dout_oe
);
    logic          en;
    logic          sel;
    cyc_e          cyc_now;
    cyc_e          cyc_q;
    logic [AW-1:0] cur_addr;

    assign en  = ~cke_n;
    assign sel = ~ce1_n & ce2 & ~ce3_n;

    nbs_cycle_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .adv_ld  (adv_ld),
        .we_n    (we_n),
        .sel     (sel),
        .cyc_now (cyc_now),
        .cyc_q   (cyc_q)
    );

    nbs_burst_addr #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .adv_ld   (adv_ld),
        .mode     (mode),
        .addr     (addr),
        .cur_addr (cur_addr)
    );

    nbs_pipe_array #(.AW(AW), .NB(NB)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .cyc     (cyc_now),
        .a_in    (cur_addr),
        .be_in   (~bw_n),
        .din     (din),
        .dout    (dout),
        .dout_oe (dout_oe)
    );
endmodule

// File: rtl/nt_burst_sram_chk.sv
module nt_burst_sram_chk
    import nbs_pkg::*;
#(
    parameter int NB = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cke_n,
    input logic            adv_ld,
    input logic            ce1_n,
    input logic            ce2,
    input logic            ce3_n,
    input cyc_e            cyc_now,
    input cyc_e            cyc_q,
    input logic [NB*8-1:0] dout,
    input logic            dout_oe
);
    logic rd1_q;
    logic rd2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd1_q <= 1'b0;
            rd2_q <= 1'b0;
        end else if (!cke_n) begin
            rd1_q <= (cyc_now == ST_READ);
            rd2_q <= rd1_q;
        end
    end

    p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(dout) && $stable(dout_oe) && $stable(cyc_q)));

    p_burst_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv_ld) |=> (cyc_q == $past(cyc_q)));

    p_deselect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld && !(!ce1_n && ce2 && !ce3_n)) |=> (cyc_q == ST_IDLE));

    p_oe_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && rd2_q) |=> dout_oe);

    p_oe_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !rd2_q) |=> !dout_oe);
endmodule

bind nt_burst_sram nt_burst_sram_chk #(.NB(NB)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cke_n   (cke_n),
    .adv_ld  (adv_ld),
    .ce1_n   (ce1_n),
    .ce2     (ce2),
    .ce3_n   (ce3_n),
    .cyc_now (cyc_now),
    .cyc_q   (cyc_q),
    .dout    (dout),
    .dout_oe (dout_oe)
);

// File: tb/nt_burst_sram_bench.sv
module nt_burst_sram_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int NB = 4;
    localparam int DW = NB * 8;
    localparam int DEPTH = 1 << AW;
    localparam int M_DES = 0;
    localparam int M_RD = 1;
    localparam int M_WR = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke_n = 1'b0;
    logic          adv_ld = 1'b0;
    logic          we_n = 1'b1;
    logic [NB-1:0] bw_n = '1;
    logic          ce1_n = 1'b1;
    logic          ce2 = 1'b0;
    logic          ce3_n = 1'b1;
    logic          mode = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_oe;

    nt_burst_sram #(.AW(AW), .NB(NB)) u_nt_burst_sram (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .adv_ld(adv_ld), .we_n(we_n),
        .bw_n(bw_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .mode(mode),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    logic [DW-1:0] mdl_mem [DEPTH];
    int            p_op [2];
    logic [AW-1:0] p_a [2];
    logic [NB-1:0] p_be [2];
    string         p_tag [2];
    int            m_op = M_DES;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;
    logic [DW-1:0] exp_dout = '0;
    logic          exp_oe = 1'b0;
    string         exec_tag = "R9";
    bit            last_stall = 1'b0;

    function automatic logic [AW-1:0] burst_addr(logic [AW-1:0] b, logic [1:0] k, logic md);
        logic [1:0] lo;
        lo = md ? (b[1:0] ^ k) : (b[1:0] + k);
        return {b[AW-1:2], lo};
    endfunction

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic compare();
        string t;
        t = last_stall ? "R2" : exec_tag;
        chk(t, {{(DW-1){1'b0}}, dout_oe}, {{(DW-1){1'b0}}, exp_oe});
        if (exp_oe || last_stall)
            chk(t, dout, exp_dout);
    endtask

    task automatic model_edge(logic a_adv, logic a_we, logic [NB-1:0] a_bw, logic a_ce1,
                              logic a_ce2, logic a_ce3, logic a_md, logic [AW-1:0] a_addr,
                              logic [DW-1:0] a_din, string tag);
        int            nop;
        logic [AW-1:0] na;
        if (!a_adv) begin
            nop    = (!a_ce1 && a_ce2 && !a_ce3) ? (a_we ? M_RD : M_WR) : M_DES;
            m_base = a_addr;
            m_cnt  = 2'd0;
            na     = a_addr;
        end else begin
            nop   = m_op;
            m_cnt = m_cnt + 2'd1;
            na    = burst_addr(m_base, m_cnt, a_md);
        end
        m_op = nop;
        exec_tag = p_tag[1];
        if (p_op[1] == M_WR) begin
            for (int b = 0; b < NB; b++)
                if (p_be[1][b]) mdl_mem[p_a[1]][b*8 +: 8] = a_din[b*8 +: 8];
        end
        if (p_op[1] == M_RD) begin
            exp_dout = mdl_mem[p_a[1]];
            exp_oe   = 1'b1;
        end else begin
            exp_oe = 1'b0;
        end
        p_op[1] = p_op[0]; p_a[1] = p_a[0]; p_be[1] = p_be[0]; p_tag[1] = p_tag[0];
        p_op[0] = nop;     p_a[0] = na;     p_be[0] = ~a_bw;   p_tag[0] = tag;
    endtask

    task automatic step(logic s_cke, logic s_adv, logic s_we, logic [NB-1:0] s_bw,
                        logic s_ce1, logic s_ce2, logic s_ce3, logic s_md,
                        logic [AW-1:0] s_addr, string tag);
        logic [DW-1:0] d;
        @(negedge clk);
        compare();
        d = $urandom;
        cke_n = s_cke; adv_ld = s_adv; we_n = s_we; bw_n = s_bw;
        ce1_n = s_ce1; ce2 = s_ce2; ce3_n = s_ce3; mode = s_md; addr = s_addr; din = d;
        @(posedge clk);
        #1;
        if (!s_cke) begin
            model_edge(s_adv, s_we, s_bw, s_ce1, s_ce2, s_ce3, s_md, s_addr, d, tag);
            last_stall = 1'b0;
        end else begin
            last_stall = 1'b1;
        end
    endtask

    task automatic ld(logic we, logic [AW-1:0] a, logic [NB-1:0] bw, logic md, string tag);
        step(1'b0, 1'b0, we, bw, 1'b0, 1'b1, 1'b0, md, a, tag);
    endtask

    task automatic adv(logic md, string tag);
        step(1'b0, 1'b1, 1'b1, 4'h0, 1'b0, 1'b1, 1'b0, md, '0, tag);
    endtask

    task automatic idle(string tag);
        step(1'b0, 1'b0, 1'b1, 4'hF, 1'b1, 1'b0, 1'b1, 1'b0, '0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 2; i++) begin
            p_op[i] = M_DES; p_a[i] = '0; p_be[i] = '0; p_tag[i] = "R9";
        end
        for (int i = 0; i < DEPTH; i++) mdl_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", {{(DW-1){1'b0}}, dout_oe}, '0);
        chk("R1", dout, '0);
        rst_n = 1'b1;

        // fill the whole array with single writes
        for (int i = 0; i < DEPTH; i++) ld(1'b0, i[AW-1:0], 4'h0, 1'b0, "R4");
        idle("R9"); idle("R9");

        // R4: partial byte mask, then read back
        ld(1'b0, 6'd5, 4'b0101, 1'b0, "R4");
        idle("R4"); idle("R4");
        ld(1'b1, 6'd5, 4'hF, 1'b0, "R4");
        idle("R4"); idle("R4");

        // R10: alternate write/read on the same word each cycle
        for (int i = 0; i < 8; i++) begin
            ld(1'b0, 6'(9 + i), 4'($urandom), 1'b0, "R10");
            ld(1'b1, 6'(9 + i), 4'hF, 1'b0, "R10");
        end
        idle("R10"); idle("R10");

        // R5: read burst, advances carry write-select and deselect values
        ld(1'b1, 6'd12, 4'hF, 1'b0, "R5");
        for (int i = 0; i < 3; i++)
            step(1'b0, 1'b1, 1'b0, 4'h0, 1'b1, 1'b0, 1'b1, 1'b0, '0, "R5");
        idle("R5"); idle("R5");

        // R7: interleaved write burst starting at low bits 2, single reads back
        ld(1'b0, 6'h16, 4'h0, 1'b1, "R7");
        for (int i = 0; i < 3; i++) adv(1'b1, "R7");
        idle("R7"); idle("R7");
        for (int i = 0; i < 4; i++) ld(1'b1, 6'(8'h14 + i), 4'hF, 1'b0, "R7");
        idle("R7"); idle("R7");

        // R8: linear write burst starting at low bits 3, single reads back
        ld(1'b0, 6'h23, 4'h0, 1'b0, "R8");
        for (int i = 0; i < 3; i++) adv(1'b0, "R8");
        idle("R8"); idle("R8");
        for (int i = 0; i < 4; i++) ld(1'b1, 6'(8'h20 + i), 4'hF, 1'b1, "R8");
        idle("R8"); idle("R8");

        // R6: each chip enable inactive on its own; writes must not land
        step(1'b0, 1'b0, 1'b1, 4'hF, 1'b1, 1'b1, 1'b0, 1'b0, 6'd3, "R6");
        step(1'b0, 1'b0, 1'b1, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 6'd3, "R6");
        step(1'b0, 1'b0, 1'b1, 4'hF, 1'b0, 1'b1, 1'b1, 1'b0, 6'd3, "R6");
        step(1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd3, "R6");
        idle("R6"); idle("R6");
        ld(1'b1, 6'd3, 4'hF, 1'b0, "R6");
        idle("R6"); idle("R6");

        // R2: stall with both a write and a read in flight
        ld(1'b0, 6'd40, 4'h0, 1'b0, "R2");
        ld(1'b1, 6'd41, 4'hF, 1'b0, "R2");
        for (int i = 0; i < 4; i++)
            step(1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 6'($urandom), "R2");
        idle("R2"); idle("R2");
        ld(1'b1, 6'd40, 4'hF, 1'b0, "R2");
        idle("R2"); idle("R2");
        ld(1'b1, 6'd7, 4'hF, 1'b0, "R3");
        step(1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 6'd9, "R2");
        idle("R3");
        step(1'b1, 1'b0, 1'b1, 4'hF, 1'b0, 1'b1, 1'b0, 1'b0, 6'd9, "R2");
        idle("R3"); idle("R3");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic r_cke, r_adv, r_we, r_md;
            string t;
            r_cke = ($urandom % 6) == 0;
            r_adv = ($urandom % 3) == 0;
            r_we  = $urandom % 2;
            r_md  = $urandom % 2;
            t = r_adv ? (r_md ? "R7" : "R8") : (r_we ? "R3" : "R4");
            step(r_cke, r_adv, r_we, 4'($urandom),
                 ($urandom % 8) == 0, ($urandom % 8) != 0, ($urandom % 8) == 0,
                 r_md, 6'($urandom), t);
        end
        idle("R9"); idle("R9"); idle("R9");
        @(negedge clk);
        compare();

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule